// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block gathers peripheral interrupt lines into nineteen numbered groups, 8 through 26. Each group has up to 32 sources. Every source has a sticky status flag and a mask bit. Only the bit positions that a group actually implements can be used.

For each group, the masked flags combine into a single aggregated line. That line is gated by a per-group block-enable bit whose position equals the group number. Groups 13 to 21 and 23 can also expose every masked flag on a separate direct line when direct routing is switched on. Group 22 is kept apart from the aggregated lines and appears only as a wake request.

Software reaches the registers through a plain single-cycle register bus. Writes happen on a clock edge, and reads are returned combinationally from the address.

Top module: `grp_irq_aggr`

## Requirements
- R1: A status flag sets on any clock edge where its input line is high, stays set after the input falls, and an unimplemented position always reads 0 (group 16 implements bits 0, 2, 3; group 20 implements bits 3, 9; group 22 implements bits 0-5, 9, 15).
- R2: Writing 1 to a bit of a group's status word (offset +0x0 of the group window at (group-8)*0x14) clears that flag. Zero bits are ignored. If an input is high in the same cycle, the flag stays set.
- R3: Writing 1s to enable-set (+0x4) sets mask bits and writing 1s to enable-clear (+0xC) clears them; zero bits leave masks unchanged, unimplemented mask bits stay 0, and both offsets read back the mask.
- R4: The result word (+0x8) reads status AND mask, and writes to it change nothing.
- R5: Aggregated line i (group 8+i) is high when its group has any result bit set and block-enable bit 8+i is set. Block-enable bits are set by writing 1s at 0x200 and cleared by writing 1s at 0x204; both addresses read back the block enables.
- R6: Group 22 never drives its aggregated line (index 14). Instead it drives wake_req under the same rule as R5, gated by block-enable bit 22.
- R7: direct_irq[32*i +: 32] equals group 8+i's result word when direct_mode is 1 and bit 8+i of the capable mask 0x00BFE000 is set; otherwise it is 0.
- R8: After reset, all flags, masks and block enables are 0, and every output is low.
- R9: Address 0x208 reads a pending word whose bit n is the OR of group n's result bits, regardless of block enable.
- R10: Reads of the reserved word (+0x10) of any group, and of any unmapped address, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| direct_mode | input | 1 | Enables direct per-source outputs |
| irq_in | input | 608 | Source lines, group 8+i at bits 32*i+31:32*i |
| agg_irq | output | 19 | Aggregated line per group |
| wake_req | output | 1 | Aggregated output of group 22 |
| direct_irq | output | 608 | Per-source direct lines |

## Verification
Every state change lands on the clock edge that samples the stimulus: an input pulse, a write, or both together. Reads and all outputs are combinational from that state, so each result is due one edge after the stimulus. The bench drives on the falling edge and samples on the next falling edge, half a period after the updating edge, so no check races the edge. Read-only behaviour, ignored zero writes and the set-over-clear collision are all observed through readback or the output pins in that same following half cycle.

// File: rtl/grp_irq_aggr.sv
module grp_irq_aggr #(
  parameter int AW = 10,
  parameter int NGRP = 19,
  parameter int FIRST = 8,
  parameter int WAKE_GRP = 22,
  parameter int WIN = 20,
  parameter logic [31:0] DIRECT_MASK = 32'h00BF_E000,
  parameter logic [NGRP*32-1:0] IMPL_MASK = {
    32'h0000_307F, 32'h0000_FFFF, 32'h0FFF_FFFF, 32'h0003_07FF,
    32'h0000_823F, 32'h060C_FFFC, 32'h0000_0208, 32'h0000_07FF,
    32'h1FF0_04FF, 32'h00F3_FF1F, 32'h0000_000D, 32'h005F_FFFF,
    32'h0000_FFFF, 32'h0000_001F, 32'h7FFF_FFFF, 32'h7FFF_FFFF,
    32'h7FFF_FFFF, 32'h3FFF_FFFF, 32'h3F67_FFFF}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 direct_mode,
  input  logic [NGRP*32-1:0]   irq_in,
  output logic [NGRP-1:0]      agg_irq,
  output logic                 wake_req,
  output logic [NGRP*32-1:0]   direct_irq
);
  localparam logic [AW-1:0] BLK_SET = AW'(12'h200);
  localparam logic [AW-1:0] BLK_CLR = AW'(12'h204);
  localparam logic [AW-1:0] BLK_PND = AW'(12'h208);
  localparam int WIDX = WAKE_GRP - FIRST;
  localparam logic [31:0] GRP_BITS = 32'(((64'd1 << NGRP) - 64'd1) << FIRST);

  logic [NGRP-1:0][31:0] stat, en, res;
  logic [31:0] blk_en, pend;

  always_ff @(posedge clk) begin
    if (!rst_n) blk_en <= '0;
    else if (reg_wr && reg_addr == BLK_SET) blk_en <= (blk_en | reg_wdata) & GRP_BITS;
    else if (reg_wr && reg_addr == BLK_CLR) blk_en <= blk_en & ~reg_wdata;
  end

  for (genvar i = 0; i < NGRP; i++) begin : g_grp
    localparam logic [AW-1:0] BASE = AW'(i * WIN);
    localparam logic [31:0] IMPL = IMPL_MASK[i*32 +: 32];
    localparam bit CAN_DIRECT = DIRECT_MASK[FIRST + i];
    logic [31:0] clr_st;

    assign clr_st = (reg_wr && reg_addr == BASE) ? reg_wdata : 32'h0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat[i] <= '0;
        en[i]   <= '0;
      end else begin
        stat[i] <= ((stat[i] & ~clr_st) | irq_in[i*32 +: 32]) & IMPL;
        if (reg_wr && reg_addr == BASE + AW'(4)) en[i] <= (en[i] | reg_wdata) & IMPL;
        else if (reg_wr && reg_addr == BASE + AW'(12)) en[i] <= en[i] & ~reg_wdata;
      end
    end

    assign res[i] = stat[i] & en[i];
    assign pend[FIRST + i] = |res[i];

    if (i == WIDX) begin : g_wake
      assign agg_irq[i] = 1'b0;
    end else begin : g_norm
      assign agg_irq[i] = pend[FIRST + i] & blk_en[FIRST + i];
    end

    if (CAN_DIRECT) begin : g_dir
      assign direct_irq[i*32 +: 32] = direct_mode ? res[i] : 32'h0;
    end else begin : g_nodir
      assign direct_irq[i*32 +: 32] = 32'h0;
    end
  end

  if (FIRST > 0) begin : g_plo
    assign pend[FIRST-1:0] = '0;
  end
  if (FIRST + NGRP < 32) begin : g_phi
    assign pend[31:FIRST+NGRP] = '0;
  end

  assign wake_req = pend[WAKE_GRP] & blk_en[WAKE_GRP];

  always_comb begin
    reg_rdata = 32'h0;
    if (reg_addr == BLK_SET || reg_addr == BLK_CLR) reg_rdata = blk_en;
    else if (reg_addr == BLK_PND) reg_rdata = pend;
    else
      for (int i = 0; i < NGRP; i++) begin
        if (reg_addr == AW'(i * WIN))       reg_rdata = stat[i];
        if (reg_addr == AW'(i * WIN + 4))   reg_rdata = en[i];
        if (reg_addr == AW'(i * WIN + 8))   reg_rdata = res[i];
        if (reg_addr == AW'(i * WIN + 12))  reg_rdata = en[i];
      end
  end
endmodule

// File: rtl/grp_irq_aggr_chk.sv
module grp_irq_aggr_chk #(
  parameter int NGRP = 19,
  parameter int FIRST = 8,
  parameter int WAKE_GRP = 22,
  parameter logic [31:0] DIRECT_MASK = 32'h00BF_E000,
  parameter logic [NGRP*32-1:0] IMPL_MASK = '0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  direct_mode,
  input logic [NGRP*32-1:0]    irq_in,
  input logic [NGRP-1:0]       agg_irq,
  input logic                  wake_req,
  input logic [NGRP*32-1:0]    direct_irq,
  input logic [NGRP-1:0][31:0] stat,
  input logic [31:0]           blk_en
);
  a_r1_latch_input: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((NGRP*32)'(stat) & $past(irq_in & IMPL_MASK)) == $past(irq_in & IMPL_MASK));

  a_r6_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> blk_en[WAKE_GRP] && !agg_irq[WAKE_GRP - FIRST]);

  a_r7_direct_off: assert property (@(posedge clk) disable iff (!rst_n)
    !direct_mode |-> direct_irq == '0);

  a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> agg_irq == '0 && !wake_req && direct_irq == '0);

  for (genvar i = 0; i < NGRP; i++) begin : g_a
    a_r5_agg_gated: assert property (@(posedge clk) disable iff (!rst_n)
      agg_irq[i] |-> blk_en[FIRST + i] && stat[i] != 32'h0);
    if (!DIRECT_MASK[FIRST + i]) begin : g_nd
      a_r7_not_capable: assert property (@(posedge clk) disable iff (!rst_n)
        direct_irq[i*32 +: 32] == 32'h0);
    end
  end
endmodule

bind grp_irq_aggr grp_irq_aggr_chk #(
  .NGRP(NGRP), .FIRST(FIRST), .WAKE_GRP(WAKE_GRP),
  .DIRECT_MASK(DIRECT_MASK), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .irq_in(irq_in),
  .agg_irq(agg_irq), .wake_req(wake_req), .direct_irq(direct_irq),
  .stat(stat), .blk_en(blk_en)
);

// File: tb/grp_irq_aggr_test.sv
module grp_irq_aggr_test;
  logic clk = 0, rst_n = 0, reg_wr = 0, direct_mode = 0;
  logic [9:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [607:0] irq_in = '0, direct_irq;
  logic [18:0] agg_irq;
  logic wake_req;
  int checks = 0, errors = 0, cycles = 0;

  grp_irq_aggr uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .direct_mode(direct_mode),
    .irq_in(irq_in), .agg_irq(agg_irq), .wake_req(wake_req), .direct_irq(direct_irq));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [9:0] ga(int grp, int off);
    return 10'((grp - 8) * 20 + off);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(int grp, logic [31:0] bits);
    @(negedge clk); irq_in[(grp-8)*32 +: 32] = bits;
    @(negedge clk); irq_in[(grp-8)*32 +: 32] = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(ga(8, 0), d);  chk("R8 status", d, 0);
    rd(ga(8, 4), d);  chk("R8 enable", d, 0);
    rd(10'h200, d);   chk("R8 blk_en", d, 0);
    chk("R8 agg", 32'(agg_irq), 0);
    chk("R8 wake", 32'(wake_req), 0);
    chk("R8 direct", 32'(|direct_irq), 0);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    pulse(16, 32'h7);
    rd(ga(16, 0), d); chk("R1 latch impl only", d, 32'h5);
    repeat (3) @(negedge clk);
    rd(ga(16, 0), d); chk("R1 sticky", d, 32'h5);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(ga(16, 0), 32'h0);
    rd(ga(16, 0), d); chk("R2 zero write ignored", d, 32'h5);
    wr(ga(16, 0), 32'h4);
    rd(ga(16, 0), d); chk("R2 clear one", d, 32'h1);
    @(negedge clk); irq_in[8*32] = 1; reg_wr = 1; reg_addr = ga(16, 0); reg_wdata = 32'h1;
    @(negedge clk); irq_in[8*32] = 0; reg_wr = 0;
    rd(ga(16, 0), d); chk("R2 set wins", d, 32'h1);
    wr(ga(16, 0), 32'h1);
    rd(ga(16, 0), d); chk("R2 cleared", d, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(ga(20, 4), 32'hFFFF_FFFF);
    rd(ga(20, 4), d);  chk("R3 set impl only", d, 32'h208);
    wr(ga(20, 12), 32'h8);
    rd(ga(20, 12), d); chk("R3 clear", d, 32'h200);
    wr(ga(20, 12), 32'h0);
    rd(ga(20, 4), d);  chk("R3 zero clear ignored", d, 32'h200);
  endtask

  task automatic t_result;
    logic [31:0] d;
    pulse(20, 32'h208);
    rd(ga(20, 8), d); chk("R4 result and", d, 32'h200);
    wr(ga(20, 8), 32'hFFFF_FFFF);
    rd(ga(20, 8), d); chk("R4 result read-only", d, 32'h200);
    rd(ga(20, 0), d); chk("R4 status untouched", d, 32'h208);
    rd(ga(20, 4), d); chk("R4 enable untouched", d, 32'h200);
  endtask

  task automatic t_agg;
    logic [31:0] d;
    chk("R5 agg off without blk", 32'(agg_irq[12]), 0);
    rd(10'h208, d); chk("R9 pending word", d, 32'h0010_0000);
    wr(10'h200, 32'h0010_0000);
    chk("R5 agg on", 32'(agg_irq), 32'h1000);
    rd(10'h204, d); chk("R5 blk readback", d, 32'h0010_0000);
    wr(10'h204, 32'h0010_0000);
    chk("R5 agg off after clear", 32'(agg_irq[12]), 0);
    rd(10'h208, d); chk("R9 pending kept", d, 32'h0010_0000);
    wr(ga(20, 0), 32'h208);
  endtask

  task automatic t_wake;
    wr(ga(22, 4), 32'h1);
    pulse(22, 32'h1);
    chk("R6 no wake without blk", 32'(wake_req), 0);
    wr(10'h200, 32'h0040_0000);
    chk("R6 wake", 32'(wake_req), 1);
    chk("R6 agg line 14 low", 32'(agg_irq), 0);
  endtask

  task automatic t_direct;
    wr(ga(13, 4), 32'h1);
    pulse(13, 32'h1);
    chk("R7 direct off", 32'(direct_irq[5*32]), 0);
    @(negedge clk); direct_mode = 1; #1;
    chk("R7 direct on", direct_irq[5*32 +: 32], 32'h1);
    wr(ga(8, 4), 32'h1);
    pulse(8, 32'h1);
    chk("R7 group 8 not capable", direct_irq[0 +: 32], 0);
    @(negedge clk); direct_mode = 0;
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(ga(8, 16), d); chk("R10 reserved word", d, 0);
    rd(10'h3FC, d);   chk("R10 unmapped", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_latch; t_w1c; t_enable; t_result;
    t_agg; t_wake; t_direct; t_unmapped;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule